// File: doc/BRIEF.md
# Power Resource State Register

This block holds the digital state of one shared power resource, such as a regulator or a clock enable. Every 16-bit power-bus message is offered to it, and the block decides whether the message is meant for it. A message can address the resource either by its fixed identifier or by its resource group and type. When a message applies, the requested state is written into one of three state registers. Each register belongs to one requesting subsystem, and the message's requester bits select which registers are written.

From those three registers the block resolves one final state. Only subsystems in the ownership mask count, and the highest state any owner asks for wins. The result then passes through two remap fields. One can turn a resolved "off" into sleep or active. The other can turn a resolved "sleep" into off or active. The final state drives one-hot off, sleep and active flags. It is also returned in the low nibble of a device-group read view, next to the ownership mask.

Messages arrive on a valid/ready stream. The block never applies back-pressure: ready is high at all times, and each valid beat is consumed in the cycle it is presented. Configuration inputs are plain levels. A change to them shows on the outputs in the same cycle.

Top module: `power_res_state`

## Requirements
- R1: When message bit 12 is 1, the message is a single-resource message. It applies only when bits [11:4] equal `res_id`.
- R2: When message bit 12 is 0, the message is a broadcast. It applies only when bits [11:9] equal `res_grp` and bits [8:6] equal `res_type` or `res_type2`.
- R3: A beat that is not valid, or a message that does not apply, leaves all three state registers unchanged.
- R4: Requester bits 13, 14 and 15 select state registers 0, 1 and 2. Every set bit of an applying message writes its register, and the write is visible on the outputs one clock after the valid beat.
- R5: States are encoded as off = 0x0, sleep = 0x8 and active = 0xE. An incoming 4-bit code of 0xE or more counts as active, 0x8 to 0xD counts as sleep, and anything below 0x8 counts as off.
- R6: Bit i of `own_mask` makes subsystem i an owner. A register whose subsystem is not an owner does not affect the output. With an empty mask the final state is off, and no remap is applied. `devgrp_view` returns {own_mask, 0, final_state}.
- R7: The resolved state is the highest state among the owners' registers, using the order off < sleep < active.
- R8: When the resolved state is off, `remap_cfg[7:4]`, classified as in R5, gives the final state.
- R9: When the resolved state is sleep, `remap_cfg[3:0]`, classified as in R5, gives the final state. A resolved active passes through unchanged.
- R10: Exactly one of `is_off`, `is_sleep` and `is_active` is high, and it matches `final_state`.
- R11: After reset all three state registers hold off.
- R12: `msg_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Message beat valid |
| msg_ready | output | 1 | Message beat accepted (always 1) |
| msg_word | input | 16 | Power-bus message |
| res_id | input | 8 | Fixed identifier of this resource |
| res_grp | input | 3 | Fixed resource group |
| res_type | input | 3 | Configured primary type |
| res_type2 | input | 3 | Configured secondary type |
| own_mask | input | 3 | Owning subsystems, bit i = subsystem i |
| remap_cfg | input | 8 | [7:4] replacement for off, [3:0] replacement for sleep |
| final_state | output | 4 | Final state code |
| is_active | output | 1 | Final state is active |
| is_sleep | output | 1 | Final state is sleep |
| is_off | output | 1 | Final state is off |
| devgrp_view | output | 8 | Read view {own_mask, 1'b0, final_state} |

## Verification
Some rules are checked by the assertions on every cycle. Idle beats leave the state registers unchanged. An identifier-addressed write for requester 0 lands one cycle later. An empty mask forces off, an owned active register forces an active output, a resolved off follows the off remap, and the flags stay one-hot. Other behaviours are shown only by the bench's scenarios. These are the broadcast matching against both configured types, writes from several requesters at once, classification of non-canonical state codes, and the sleep remap. Owner-only merging under changing masks is also left to the bench.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int STATE_W = 4;
  localparam logic [STATE_W-1:0] CODE_OFF    = 4'h0;
  localparam logic [STATE_W-1:0] CODE_SLEEP  = 4'h8;
  localparam logic [STATE_W-1:0] CODE_ACTIVE = 4'hE;

  typedef enum logic [1:0] {
    RK_OFF    = 2'd0,
    RK_SLEEP  = 2'd1,
    RK_ACTIVE = 2'd2
  } rank_t;

  // Classify any 4-bit state code into one of three ranks
  function automatic rank_t rank_of(input logic [STATE_W-1:0] code);
    if (code >= CODE_ACTIVE) return RK_ACTIVE;
    if (code >= CODE_SLEEP)  return RK_SLEEP;
    return RK_OFF;
  endfunction

  function automatic logic [STATE_W-1:0] code_of(input rank_t r);
    case (r)
      RK_ACTIVE: return CODE_ACTIVE;
      RK_SLEEP:  return CODE_SLEEP;
      default:   return CODE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/prs_msg_decode.sv
module prs_msg_decode
  import prs_pkg::*;
#(
  parameter int MSG_W   = 16,
  parameter int NUM_REQ = 3,
  parameter int ID_W    = 8,
  parameter int GRP_W   = 3,
  parameter int TYPE_W  = 3
) (
  input  logic               msg_valid,
  input  logic [MSG_W-1:0]   msg_word,
  input  logic [ID_W-1:0]    res_id,
  input  logic [GRP_W-1:0]   res_grp,
  input  logic [TYPE_W-1:0]  res_type,
  input  logic [TYPE_W-1:0]  res_type2,
  output logic [NUM_REQ-1:0] wr_en,
  output rank_t              wr_rank
);
  localparam int REQ_LSB  = MSG_W - NUM_REQ;
  localparam int MT_BIT   = REQ_LSB - 1;
  localparam int ID_LSB   = MT_BIT - ID_W;
  localparam int GRP_LSB  = MT_BIT - GRP_W;
  localparam int TYPE_LSB = GRP_LSB - TYPE_W;

  logic              single_msg;
  logic              id_hit;
  logic              grp_hit;
  logic              type_hit;
  logic              applies;
  logic [TYPE_W-1:0] msg_type;

  always_comb begin
    single_msg = msg_word[MT_BIT];
    id_hit     = (msg_word[MT_BIT-1:ID_LSB] == res_id);
    grp_hit    = (msg_word[MT_BIT-1:GRP_LSB] == res_grp);
    msg_type   = msg_word[GRP_LSB-1:TYPE_LSB];
    type_hit   = (msg_type == res_type) || (msg_type == res_type2);
    applies    = msg_valid && (single_msg ? id_hit : (grp_hit && type_hit));
    wr_en      = applies ? msg_word[MSG_W-1:REQ_LSB] : '0;
    wr_rank    = rank_of(msg_word[STATE_W-1:0]);
  end
endmodule

// File: rtl/prs_req_bank.sv
module prs_req_bank
  import prs_pkg::*;
#(
  parameter int NUM_REQ = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       wr_en,
  input  rank_t                    wr_rank,
  output rank_t [NUM_REQ-1:0]      req_rank
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        req_rank[g] <= RK_OFF;
      else if (wr_en[g]) req_rank[g] <= wr_rank;
    end
  end
endmodule

// File: rtl/prs_resolve.sv
module prs_resolve
  import prs_pkg::*;
#(
  parameter int NUM_REQ = 3
) (
  input  rank_t [NUM_REQ-1:0] req_rank,
  input  logic  [NUM_REQ-1:0] own_mask,
  input  logic  [STATE_W-1:0] remap_off_code,
  input  logic  [STATE_W-1:0] remap_sleep_code,
  output rank_t               merged,
  output rank_t               final_rank
);
  always_comb begin
    merged = RK_OFF;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (own_mask[i] && (req_rank[i] > merged)) merged = req_rank[i];
    end
  end

  always_comb begin
    if (own_mask == '0) begin
      final_rank = RK_OFF;
    end else begin
      case (merged)
        RK_OFF:   final_rank = rank_of(remap_off_code);
        RK_SLEEP: final_rank = rank_of(remap_sleep_code);
        default:  final_rank = merged;
      endcase
    end
  end
endmodule

// File: rtl/power_res_state.sv
module power_res_state
  import prs_pkg::*;
#(
  parameter int MSG_W   = 16,
  parameter int NUM_REQ = 3,
  parameter int ID_W    = 8,
  parameter int GRP_W   = 3,
  parameter int TYPE_W  = 3,
  parameter int CFG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [MSG_W-1:0]   msg_word,
  input  logic [ID_W-1:0]    res_id,
  input  logic [GRP_W-1:0]   res_grp,
  input  logic [TYPE_W-1:0]  res_type,
  input  logic [TYPE_W-1:0]  res_type2,
  input  logic [NUM_REQ-1:0] own_mask,
  input  logic [CFG_W-1:0]   remap_cfg,
  output logic [STATE_W-1:0] final_state,
  output logic               is_active,
  output logic               is_sleep,
  output logic               is_off,
  output logic [CFG_W-1:0]   devgrp_view
);
  localparam int PAD_W = CFG_W - NUM_REQ - STATE_W;

  logic [NUM_REQ-1:0]  wr_en;
  rank_t               wr_rank;
  rank_t [NUM_REQ-1:0] req_rank;
  rank_t               merged;
  rank_t               final_rank;

  prs_msg_decode #(
    .MSG_W(MSG_W), .NUM_REQ(NUM_REQ), .ID_W(ID_W), .GRP_W(GRP_W), .TYPE_W(TYPE_W)
  ) u_decode (
    .msg_valid (msg_valid),
    .msg_word  (msg_word),
    .res_id    (res_id),
    .res_grp   (res_grp),
    .res_type  (res_type),
    .res_type2 (res_type2),
    .wr_en     (wr_en),
    .wr_rank   (wr_rank)
  );

  prs_req_bank #(.NUM_REQ(NUM_REQ)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_rank  (wr_rank),
    .req_rank (req_rank)
  );

  prs_resolve #(.NUM_REQ(NUM_REQ)) u_resolve (
    .req_rank         (req_rank),
    .own_mask         (own_mask),
    .remap_off_code   (remap_cfg[CFG_W-1:CFG_W-STATE_W]),
    .remap_sleep_code (remap_cfg[STATE_W-1:0]),
    .merged           (merged),
    .final_rank       (final_rank)
  );

  always_comb begin
    msg_ready   = 1'b1;
    final_state = code_of(final_rank);
    is_active   = (final_rank == RK_ACTIVE);
    is_sleep    = (final_rank == RK_SLEEP);
    is_off      = (final_rank == RK_OFF);
    devgrp_view = {own_mask, {PAD_W{1'b0}}, final_state};
  end
endmodule

// File: rtl/prs_checker.sv
module prs_checker
  import prs_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic [15:0]         msg_word,
  input logic [7:0]          res_id,
  input logic [2:0]          own_mask,
  input logic [7:0]          remap_cfg,
  input logic [STATE_W-1:0]  final_state,
  input logic                is_active,
  input logic                is_sleep,
  input logic                is_off,
  input rank_t [2:0]         req_rank,
  input rank_t               merged
);
  p_id_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_word[12] && (msg_word[11:4] == res_id) && msg_word[13])
    |=> (req_rank[0] == rank_of($past(msg_word[3:0]))));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> $stable(req_rank));

  p_empty_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_mask == 3'b000) |-> (final_state == CODE_OFF));

  p_owner_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_mask[0] && (req_rank[0] == RK_ACTIVE)) |-> (final_state == CODE_ACTIVE));

  p_remap_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_mask != 3'b000) && (merged == RK_OFF))
    |-> (rank_of(final_state) == rank_of(remap_cfg[7:4])));

  p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({is_active, is_sleep, is_off}));
endmodule

bind power_res_state prs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_word    (msg_word),
  .res_id      (res_id),
  .own_mask    (own_mask),
  .remap_cfg   (remap_cfg),
  .final_state (final_state),
  .is_active   (is_active),
  .is_sleep    (is_sleep),
  .is_off      (is_off),
  .req_rank    (req_rank),
  .merged      (merged)
);

// File: tb/power_res_state_test.sv
module power_res_state_test;
  localparam logic [7:0] MY_ID = 8'h5A;
  localparam logic [2:0] MY_GRP = 3'd2;
  localparam logic [2:0] MY_T1 = 3'd1;
  localparam logic [2:0] MY_T2 = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [15:0] msg_word = '0;
  logic [2:0]  own_mask = 3'b111;
  logic [7:0]  remap_cfg = 8'h00;
  logic [3:0]  final_state;
  logic        is_active, is_sleep, is_off;
  logic [7:0]  devgrp_view;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [1:0] m_rk [3];

  always #2 clk = ~clk;

  power_res_state uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_word(msg_word), .res_id(MY_ID), .res_grp(MY_GRP), .res_type(MY_T1),
    .res_type2(MY_T2), .own_mask(own_mask), .remap_cfg(remap_cfg),
    .final_state(final_state), .is_active(is_active), .is_sleep(is_sleep),
    .is_off(is_off), .devgrp_view(devgrp_view)
  );

  function automatic logic [1:0] f_rank(input logic [3:0] c);
    if (c >= 4'hE) return 2'd2;
    if (c >= 4'h8) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [3:0] f_code(input logic [1:0] r);
    return (r == 2'd2) ? 4'hE : (r == 2'd1) ? 4'h8 : 4'h0;
  endfunction

  function automatic bit f_applies(input logic [15:0] w);
    if (w[12]) return w[11:4] == MY_ID;
    return (w[11:9] == MY_GRP) && ((w[8:6] == MY_T1) || (w[8:6] == MY_T2));
  endfunction

  function automatic logic [3:0] f_final(input logic [2:0] own, input logic [7:0] rmp);
    logic [1:0] mx = 2'd0;
    if (own == 3'b000) return 4'h0;
    for (int i = 0; i < 3; i++) if (own[i] && m_rk[i] > mx) mx = m_rk[i];
    if (mx == 2'd0) return f_code(f_rank(rmp[7:4]));
    if (mx == 2'd1) return f_code(f_rank(rmp[3:0]));
    return 4'hE;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [3:0] e = f_final(own_mask, remap_cfg);
    chk(req, {4'h0, final_state}, {4'h0, e});
    chk("R10 flags", {5'b0, is_active, is_sleep, is_off},
        {5'b0, e == 4'hE, e == 4'h8, e == 4'h0});
    chk("R6 view", devgrp_view, {own_mask, 1'b0, e});
    chk("R12 ready", {7'b0, msg_ready}, 8'h01);
  endtask

  task automatic send(input logic v, input logic [15:0] w, input string req);
    @(negedge clk);
    msg_valid = v;
    msg_word  = w;
    @(posedge clk);
    #1;
    if (v && f_applies(w))
      for (int i = 0; i < 3; i++) if (w[13+i]) m_rk[i] = f_rank(w[3:0]);
    msg_valid = 1'b0;
    check_all(req);
  endtask

  task automatic set_cfg(input logic [2:0] own, input logic [7:0] rmp, input string req);
    @(negedge clk);
    own_mask  = own;
    remap_cfg = rmp;
    #1;
    check_all(req);
  endtask

  function automatic logic [15:0] single_w(input logic [2:0] rq, input logic [7:0] id, input logic [3:0] st);
    return {rq, 1'b1, id, st};
  endfunction

  function automatic logic [15:0] bcast_w(input logic [2:0] rq, input logic [2:0] g, input logic [2:0] t, input logic [3:0] st);
    return {rq, 1'b0, g, t, 2'b00, st};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) m_rk[i] = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R11 reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R11 after reset");

    // R1 single-resource write, requester 0
    set_cfg(3'b001, 8'h00, "R6 own0");
    send(1'b1, single_w(3'b001, MY_ID, 4'hE), "R1 id match");
    // R3 mismatched id, requester 1 active, observed by owning only 1
    set_cfg(3'b010, 8'h00, "R6 own1");
    send(1'b1, single_w(3'b010, MY_ID ^ 8'h01, 4'hE), "R3 id mismatch");
    send(1'b0, single_w(3'b010, MY_ID, 4'hE), "R3 valid low");
    // R2 broadcast on secondary type, then primary, then mismatch group
    send(1'b1, bcast_w(3'b010, MY_GRP, MY_T2, 4'h8), "R2 type2");
    send(1'b1, bcast_w(3'b010, MY_GRP, MY_T1, 4'hE), "R2 type1");
    send(1'b1, bcast_w(3'b010, MY_GRP ^ 3'd1, MY_T1, 4'h0), "R2 grp mismatch");
    send(1'b1, bcast_w(3'b010, MY_GRP, 3'd7, 4'h0), "R2 type mismatch");
    // R4 multiple requesters in one message
    send(1'b1, single_w(3'b111, MY_ID, 4'h8), "R4 all req");
    set_cfg(3'b100, 8'h00, "R4 own2");
    // R5 code classification
    send(1'b1, single_w(3'b100, MY_ID, 4'hB), "R5 0xB sleep");
    send(1'b1, single_w(3'b100, MY_ID, 4'hF), "R5 0xF active");
    send(1'b1, single_w(3'b100, MY_ID, 4'h7), "R5 0x7 off");
    // R7 highest among owners; R6 non-owner ignored
    send(1'b1, single_w(3'b001, MY_ID, 4'h8), "R7 req0 sleep");
    send(1'b1, single_w(3'b010, MY_ID, 4'hE), "R7 req1 active");
    set_cfg(3'b011, 8'h00, "R7 highest");
    set_cfg(3'b001, 8'h00, "R6 non-owner ignored");
    // R9 sleep remap
    set_cfg(3'b001, 8'h0E, "R9 sleep to active");
    set_cfg(3'b001, 8'h03, "R9 sleep to off");
    // R8 off remap
    send(1'b1, single_w(3'b111, MY_ID, 4'h0), "R8 all off");
    set_cfg(3'b111, 8'hE0, "R8 off to active");
    set_cfg(3'b111, 8'h80, "R8 off to sleep");
    // R6 empty mask ignores remap
    set_cfg(3'b000, 8'hE8, "R6 empty mask");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] w = 16'($urandom);
      if ($urandom_range(0, 9) == 0)
        set_cfg(3'($urandom), 8'($urandom), "R7 random cfg");
      if (w[12]) begin
        if ($urandom_range(0, 9) < 7) w[11:4] = MY_ID;
      end else begin
        if ($urandom_range(0, 9) < 7) w[11:9] = MY_GRP;
        case ($urandom_range(0, 2))
          0: w[8:6] = MY_T1;
          1: w[8:6] = MY_T2;
          default: ;
        endcase
      end
      send($urandom_range(0, 7) != 0, w, "R4 random msg");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule